// File: doc/BRIEF.md
# Row-Buffered Bit-Addressable DRAM Array Controller

This block holds a small bit-addressable store built as a grid of rows, where each cell keeps one bit, and reaches that store only through a single full-row buffer. A host request carries a bit address, a write flag and one write bit. The high address bits pick a row and the low address bits pick a column. Every access first moves the whole chosen row into the buffer. Moving a row out clears it in the grid, so the row must be put back afterwards.

On a read, the controller returns the selected buffer bit with a one-cycle valid pulse and restores the row in that same cycle. On a write, it changes the addressed bit in the buffer and then stores the full row in an extra cycle, so a write keeps the host waiting longer than a read. A background timer also requests a refresh at a fixed interval. A refresh loads and restores one row, taking the rows in turn. A pending refresh wins over a host request that arrives at the same time.

Top module: `rowbuf_dram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rd_valid` is 0, and every bit reads back as 0.
- R2: ROWS and COLS are powers of two. The address is `row*COLS + col`: the upper log2(ROWS) bits select the row and the lower log2(COLS) bits select the column within it.
- R3: A read gives exactly one `rd_valid` pulse, in the second cycle after acceptance, with `rd_data` equal to the stored bit. `req_ready` stays low for 2 cycles after the accepting edge.
- R4: A read does not change the stored data. Repeated reads return the same bit, and every other bit of the row keeps its value.
- R5: A write changes only the addressed bit. Every other bit in that row and in every other row keeps its value.
- R6: A write never raises `rd_valid`, and it holds `req_ready` low for 3 cycles after the accepting edge.
- R7: With no host traffic, the first refresh makes `req_ready` fall at the REFRESH_INTERVAL-th cycle after reset release. Later refreshes follow every REFRESH_INTERVAL cycles, and each one holds `req_ready` low for 3 cycles.
- R8: Refreshes, which visit every row in turn, leave all stored data unchanged.
- R9: While a refresh is pending, a waiting host request is not accepted. It is accepted only after the refresh has finished.
- R10: `req_ready` is high only while the sequencer is idle and no refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears grid, buffer, timer and row pointer |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on an edge where valid and ready are both high |
| req_addr | input | log2(ROWS)+log2(COLS) | Bit address: row in upper bits, column in lower bits |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rd_data | output | 1 | Read bit, meaningful while rd_valid is high |
| rd_valid | output | 1 | One-cycle pulse carrying read data |

## Verification
The assertions assume the host keeps `req_addr`, `req_wr` and `req_wdata` stable while `req_valid` is high, and that it only counts a request as taken on an edge where `req_ready` was high. The stimulus drives a request at a falling edge and holds it until a falling edge sees `req_ready` high. It then lowers `req_valid` after the next rising edge, so the host never changes a request while it waits. Random addresses are cut back to one row about half the time, which produces many row collisions. Directed cases cover the edge columns, repeated reads, a request held through a refresh, and a long idle stretch in which every row is refreshed.

// File: rtl/rbdram_pkg.sv
package rbdram_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_LOAD    = 3'd1,
    S_ACCESS  = 3'd2,
    S_WBACK   = 3'd3,
    S_REFRESH = 3'd4
  } seq_state_t;

  // width of an index into n items, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rb_refresh_timer.sv
module rb_refresh_timer #(
  parameter int unsigned ROWS             = 16,
  parameter int unsigned REFRESH_INTERVAL = 256,
  localparam int unsigned RB = rbdram_pkg::idx_bits(ROWS),
  localparam int unsigned CW = rbdram_pkg::idx_bits(REFRESH_INTERVAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_start,
  input  logic          ref_done,
  output logic          refresh_pending,
  output logic [RB-1:0] ref_row
);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(REFRESH_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_pending <= 1'b0;
    end else if (tick) begin
      refresh_pending <= 1'b1;
    end else if (ref_start) begin
      refresh_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= (ref_row == RB'(ROWS - 1)) ? '0 : ref_row + 1'b1;
    end
  end

endmodule

// File: rtl/rb_cell_array.sv
module rb_cell_array #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 32,
  localparam int unsigned RB = rbdram_pkg::idx_bits(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RB-1:0]   sel_row,
  input  logic            drain_en,
  input  logic            fill_en,
  input  logic [COLS-1:0] fill_data,
  output logic [COLS-1:0] row_out
);

  logic [COLS-1:0] cells [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = (sel_row == RB'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[r] <= '0;
      end else if (hit && fill_en) begin
        cells[r] <= fill_data;
      end else if (hit && drain_en) begin
        // sensing empties the row
        cells[r] <= '0;
      end
    end
  end

  assign row_out = cells[sel_row];

endmodule

// File: rtl/rb_row_buffer.sv
module rb_row_buffer #(
  parameter int unsigned COLS = 32,
  localparam int unsigned CB = rbdram_pkg::idx_bits(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_en,
  input  logic [COLS-1:0] latch_data,
  input  logic            patch_en,
  input  logic [CB-1:0]   col,
  input  logic            patch_bit,
  output logic [COLS-1:0] line_q,
  output logic            pick_bit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (latch_en) begin
      line_q <= latch_data;
    end else if (patch_en) begin
      line_q[col] <= patch_bit;
    end
  end

  assign pick_bit = line_q[col];

endmodule

// File: rtl/rb_seq_fsm.sv
module rb_seq_fsm
  import rbdram_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 32,
  localparam int unsigned RB = idx_bits(ROWS),
  localparam int unsigned CB = idx_bits(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_wr,
  input  logic [RB-1:0] req_row,
  input  logic [CB-1:0] req_col,
  input  logic          req_wdata,
  input  logic          refresh_pending,
  input  logic [RB-1:0] ref_row,
  output seq_state_t    state,
  output logic          req_ready,
  output logic          ref_start,
  output logic          ref_done,
  output logic [RB-1:0] op_row,
  output logic [CB-1:0] op_col,
  output logic          op_wr,
  output logic          op_wdata
);

  seq_state_t state_n;
  logic       accept;
  logic       op_ref;

  assign req_ready = (state == S_IDLE) && !refresh_pending;
  assign accept    = req_valid && req_ready;
  assign ref_start = (state == S_IDLE) && refresh_pending;
  assign ref_done  = (state == S_WBACK) && op_ref;

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:    if (ref_start) state_n = S_REFRESH;
                 else if (accept) state_n = S_LOAD;
      S_LOAD:    state_n = S_ACCESS;
      S_ACCESS:  state_n = op_wr ? S_WBACK : S_IDLE;
      S_WBACK:   state_n = S_IDLE;
      S_REFRESH: state_n = S_WBACK;
      default:   state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      state <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_row   <= '0;
      op_col   <= '0;
      op_wr    <= 1'b0;
      op_wdata <= 1'b0;
      op_ref   <= 1'b0;
    end else if (ref_start) begin
      op_row <= ref_row;
      op_wr  <= 1'b0;
      op_ref <= 1'b1;
    end else if (accept) begin
      op_row   <= req_row;
      op_col   <= req_col;
      op_wr    <= req_wr;
      op_wdata <= req_wdata;
      op_ref   <= 1'b0;
    end
  end

endmodule

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl
  import rbdram_pkg::*;
#(
  parameter int unsigned ROWS             = 16,
  parameter int unsigned COLS             = 32,
  parameter int unsigned REFRESH_INTERVAL = 256,
  localparam int unsigned RB = idx_bits(ROWS),
  localparam int unsigned CB = idx_bits(COLS),
  localparam int unsigned AW = RB + CB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic          req_wdata,
  output logic          rd_data,
  output logic          rd_valid
);

  function automatic logic [RB-1:0] row_field(input logic [AW-1:0] a);
    return a[AW-1:CB];
  endfunction

  function automatic logic [CB-1:0] col_field(input logic [AW-1:0] a);
    return a[CB-1:0];
  endfunction

  seq_state_t      state;
  logic            refresh_pending;
  logic [RB-1:0]   ref_row;
  logic            ref_start;
  logic            ref_done;
  logic [RB-1:0]   op_row;
  logic [CB-1:0]   op_col;
  logic            op_wr;
  logic            op_wdata;
  logic [COLS-1:0] grid_row;
  logic [COLS-1:0] line_q;
  logic            pick_bit;

  // named events for the checker
  logic st_idle, st_load, st_access, st_wback, st_refresh;
  logic load_en, store_en, patch_en;

  assign st_idle    = (state == S_IDLE);
  assign st_load    = (state == S_LOAD);
  assign st_access  = (state == S_ACCESS);
  assign st_wback   = (state == S_WBACK);
  assign st_refresh = (state == S_REFRESH);

  assign load_en  = st_load || st_refresh;
  assign patch_en = st_access && op_wr;
  assign store_en = (st_access && !op_wr) || st_wback;

  rb_seq_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_wr          (req_wr),
    .req_row         (row_field(req_addr)),
    .req_col         (col_field(req_addr)),
    .req_wdata       (req_wdata),
    .refresh_pending (refresh_pending),
    .ref_row         (ref_row),
    .state           (state),
    .req_ready       (req_ready),
    .ref_start       (ref_start),
    .ref_done        (ref_done),
    .op_row          (op_row),
    .op_col          (op_col),
    .op_wr           (op_wr),
    .op_wdata        (op_wdata)
  );

  rb_refresh_timer #(.ROWS(ROWS), .REFRESH_INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk             (clk),
    .rst_n           (rst_n),
    .ref_start       (ref_start),
    .ref_done        (ref_done),
    .refresh_pending (refresh_pending),
    .ref_row         (ref_row)
  );

  rb_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_grid (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_row   (op_row),
    .drain_en  (load_en),
    .fill_en   (store_en),
    .fill_data (line_q),
    .row_out   (grid_row)
  );

  rb_row_buffer #(.COLS(COLS)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_en   (load_en),
    .latch_data (grid_row),
    .patch_en   (patch_en),
    .col        (op_col),
    .patch_bit  (op_wdata),
    .line_q     (line_q),
    .pick_bit   (pick_bit)
  );

  assign rd_valid = st_access && !op_wr;
  assign rd_data  = rd_valid && pick_bit;

endmodule

// File: rtl/rowbuf_dram_chk.sv
module rowbuf_dram_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic refresh_pending,
  input logic st_idle,
  input logic st_load,
  input logic st_access,
  input logic st_wback,
  input logic st_refresh,
  input logic op_wr,
  input logic load_en,
  input logic store_en
);

  a_r10_ready_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> st_idle);

  a_r10_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_idle, st_load, st_access, st_wback, st_refresh}));

  a_r9_refresh_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && refresh_pending) |-> !req_ready);

  a_r9_refresh_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && refresh_pending) |=> st_refresh);

  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r3_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(st_load));

  a_r4_read_restores: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> store_en);

  a_r4_no_load_store_clash: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, store_en}));

  a_r6_no_valid_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_access && op_wr) |-> !rd_valid);

  a_r5_write_stores_row: assert property (@(posedge clk) disable iff (!rst_n)
    (st_access && op_wr) |=> (st_wback && store_en));

  a_r7_refresh_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
    st_refresh |=> st_wback);

endmodule

bind rowbuf_dram_ctrl rowbuf_dram_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .rd_valid        (rd_valid),
  .refresh_pending (refresh_pending),
  .st_idle         (st_idle),
  .st_load         (st_load),
  .st_access       (st_access),
  .st_wback        (st_wback),
  .st_refresh      (st_refresh),
  .op_wr           (op_wr),
  .load_en         (load_en),
  .store_en        (store_en)
);

// File: tb/test_rowbuf_dram_ctrl.sv
module test_rowbuf_dram_ctrl;

  localparam int ROWS = 16;
  localparam int COLS = 32;
  localparam int IVL  = 256;
  localparam int AW   = $clog2(ROWS) + $clog2(COLS);
  localparam int NBIT = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_wr = 1'b0;
  logic req_wdata = 1'b0;
  logic req_ready, rd_data, rd_valid;

  int checks = 0;
  int errors = 0;
  bit model [NBIT];

  always #10 clk = ~clk;

  rowbuf_dram_ctrl i_rowbuf_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic int mk_addr(input int row, input int col);
    return row * COLS + col;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input int a, input bit wd,
                       output int busy, output int vcnt, output bit data);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; vcnt = 0; data = 1'b0;
    while (!req_ready) begin
      busy++;
      if (rd_valid) begin vcnt++; data = rd_data; end
      @(negedge clk);
    end
  endtask

  task automatic do_read(input int a, input string req);
    int busy, vcnt; bit data;
    do_op(1'b0, a, 1'b0, busy, vcnt, data);
    chk(vcnt == 1, "R3", "read valid pulses", vcnt, 1);
    chk(busy == 2 || busy == 5, "R3", "read busy cycles", busy, 2);
    chk(data == model[a], req, $sformatf("read bit at %0d", a), data, model[a]);
  endtask

  task automatic do_write(input int a, input bit wd);
    int busy, vcnt; bit data;
    do_op(1'b1, a, wd, busy, vcnt, data);
    chk(vcnt == 0, "R6", "write valid pulses", vcnt, 0);
    chk(busy == 3 || busy == 6, "R6", "write busy cycles", busy, 3);
    model[a] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first_fall, lows, gap, wait_lows, seed;
    seed = $urandom(32'd7731);
    for (int i = 0; i < NBIT; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset outputs
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);

    // R7 first refresh timing and duration
    first_fall = 0; lows = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (!req_ready) begin
        lows++;
        if (first_fall == 0) first_fall = k;
      end
    end
    chk(first_fall == IVL, "R7", "first refresh cycle", first_fall, IVL);
    chk(lows == 3, "R7", "refresh busy cycles", lows, 3);

    // R9 request held across the next refresh
    gap = 300;
    while (req_ready) begin @(negedge clk); gap++; end
    chk(gap == 2 * IVL, "R7", "second refresh cycle", gap, 2 * IVL);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = '0;
    wait_lows = 0;
    while (!req_ready) begin
      wait_lows++;
      chk(!rd_valid, "R9", "no read during refresh", rd_valid, 0);
      @(negedge clk);
    end
    chk(wait_lows == 3, "R9", "request wait cycles", wait_lows, 3);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);

    // R1 cleared contents, sample across rows
    for (int r = 0; r < ROWS; r++) do_read(mk_addr(r, (r * 7) % COLS), "R1");

    // R2/R5 edge columns
    do_write(mk_addr(ROWS - 1, COLS - 1), 1'b1);
    do_write(mk_addr(ROWS - 1, 0), 1'b1);
    do_read(mk_addr(ROWS - 1, COLS - 2), "R5");
    do_read(mk_addr(ROWS - 1, 1), "R5");
    do_read(mk_addr(ROWS - 2, COLS - 1), "R5");
    do_read(mk_addr(0, COLS - 1), "R2");
    do_read(mk_addr(ROWS - 1, COLS - 1), "R2");
    do_read(mk_addr(ROWS - 1, 0), "R2");

    // R4 repeated reads of same row
    do_write(mk_addr(5, 9), 1'b1);
    for (int i = 0; i < 3; i++) do_read(mk_addr(5, 9), "R4");
    for (int c = 0; c < COLS; c += 5) do_read(mk_addr(5, c), "R4");

    // random mix, half confined to one row
    for (int i = 0; i < 300; i++) begin
      int a;
      a = ($urandom % 2) ? mk_addr(3, $urandom % COLS) : int'($urandom % NBIT);
      if ($urandom % 2) do_write(a, 1'(($urandom)));
      else do_read(a, "R5");
    end

    // R8 idle long enough to refresh every row, then full sweep
    repeat (ROWS * IVL + 100) @(negedge clk);
    for (int a = 0; a < NBIT; a++) do_read(a, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule